// File: doc/BRIEF.md
# Packed-Halfword Signed Multiplier

This block multiplies two signed 16-bit values that are each picked out of a 32-bit source word. A source word carries two independent halfwords, for example the real and imaginary parts of one complex sample. A select bit per operand names which half of that operand's word is used. The two operand selections are independent, so a real part can be multiplied by a real or an imaginary part without unpacking the words first.

The full 32-bit two's-complement product is captured in an output register at the clock edge where the input strobe is high. It appears together with a valid flag and a caller-supplied destination tag one cycle later. When the strobe is low, the registered product and tag keep their last values and the output valid flag drops. The external reset is asynchronous and active low. It clears the outputs at once. Its release is synchronised to the clock inside the block, so the unit accepts work from the third rising edge after release.

Top module: `pkmul_unit`

## Requirements
- R1: While reset is asserted, out_valid, out_prod and out_tag are all zero, independent of the clock.
- R2: A select bit of 1 takes bits [31:16] of its operand word, and a select bit of 0 takes bits [15:0]. The choice is made separately for operand A (a_hi) and operand B (b_hi).
- R3: out_prod is the exact signed 32-bit product of the two selected halves, each read as a 16-bit two's-complement number.
- R4: The product of -32768 and -32768 is reported as 0x40000000, and no other indication is given.
- R5: out_valid is high in the cycle after a cycle in which in_valid was high at the clock edge, and low after a cycle in which in_valid was low.
- R6: out_tag equals the in_tag that was presented together with the accepted operands, with the same one-cycle latency as the product.
- R7: While in_valid is low, out_prod and out_tag hold their previous values, whatever the operand, select and tag inputs do.
- R8: The halfword that is not selected in an operand word has no effect on out_prod.
- R9: Operands presented on consecutive cycles each produce their own result on the following cycle, in order, with no idle cycle needed between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset; release synchronised internally |
| in_valid | input | 1 | Operands and tag are presented this cycle |
| a_word | input | 32 | Packed source word for operand A |
| b_word | input | 32 | Packed source word for operand B |
| a_hi | input | 1 | Operand A half select: 1 = upper, 0 = lower |
| b_hi | input | 1 | Operand B half select: 1 = upper, 0 = lower |
| in_tag | input | 5 | Destination tag carried with the operation |
| out_valid | output | 1 | Registered result is new this cycle |
| out_prod | output | 32 | Signed 32-bit product |
| out_tag | output | 5 | Tag belonging to out_prod |

## Verification
The bench builds the unit with its default widths: 16-bit halves and a 5-bit tag. At these widths the extreme signed operands -32768 and +32767 can be written directly as vector constants. This brings the lone positive-overflow candidate and both mixed-sign extremes within reach of a small table. The 5-bit tag is wide enough to give every vector in the table its own tag value, so any slip in ordering or latency between the product and its tag changes a checked value.

// File: rtl/pkhm_pkg.sv
package pkhm_pkg;

  // Half-select encoding shared by the selector and its checker.
  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_sel_e;

  localparam int unsigned NUM_OPERANDS = 2;

endpackage

// File: rtl/pkhm_rst_sync.sv
module pkhm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_core_n = sync_q[STAGES-1];

endmodule

// File: rtl/pkhm_half_pick.sv
module pkhm_half_pick
  import pkhm_pkg::*;
#(
  parameter int unsigned HALF_W = 16,
  localparam int unsigned WORD_W = 2 * HALF_W
) (
  input  logic [WORD_W-1:0]        word,
  input  logic                     hi,
  output logic signed [HALF_W-1:0] half
);

  half_sel_e sel;

  always_comb begin
    sel = half_sel_e'(hi);
    if (sel == HALF_HI) begin
      half = word[WORD_W-1:HALF_W];
    end else begin
      half = word[HALF_W-1:0];
    end
  end

endmodule

// File: rtl/pkhm_smul.sv
module pkhm_smul #(
  parameter int unsigned HALF_W = 16,
  localparam int unsigned PROD_W = 2 * HALF_W
) (
  input  logic signed [HALF_W-1:0] x,
  input  logic signed [HALF_W-1:0] y,
  output logic signed [PROD_W-1:0] p
);

  logic signed [PROD_W-1:0] x_ext;
  logic signed [PROD_W-1:0] y_ext;

  always_comb begin
    x_ext = PROD_W'(x);
    y_ext = PROD_W'(y);
    p     = x_ext * y_ext;
  end

endmodule

// File: rtl/pkhm_out_stage.sv
module pkhm_out_stage #(
  parameter int unsigned PROD_W = 32,
  parameter int unsigned TAG_W  = 5
) (
  input  logic              clk,
  input  logic              rst_core_n,
  input  logic              en,
  input  logic [PROD_W-1:0] prod_d,
  input  logic [TAG_W-1:0]  tag_d,
  output logic              valid_q,
  output logic [PROD_W-1:0] prod_q,
  output logic [TAG_W-1:0]  tag_q
);

  logic              valid_n;
  logic [PROD_W-1:0] prod_n;
  logic [TAG_W-1:0]  tag_n;

  always_comb begin
    valid_n = en;
    prod_n  = prod_q;
    tag_n   = tag_q;
    if (en) begin
      prod_n = prod_d;
      tag_n  = tag_d;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      valid_q <= 1'b0;
      prod_q  <= '0;
      tag_q   <= '0;
    end else begin
      valid_q <= valid_n;
      prod_q  <= prod_n;
      tag_q   <= tag_n;
    end
  end

endmodule

// File: rtl/pkmul_unit.sv
module pkmul_unit
  import pkhm_pkg::*;
#(
  parameter int unsigned HALF_W     = 16,
  parameter int unsigned TAG_W      = 5,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned WORD_W    = 2 * HALF_W,
  localparam int unsigned PROD_W    = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] a_word,
  input  logic [WORD_W-1:0] b_word,
  input  logic              a_hi,
  input  logic              b_hi,
  input  logic [TAG_W-1:0]  in_tag,
  output logic              out_valid,
  output logic [PROD_W-1:0] out_prod,
  output logic [TAG_W-1:0]  out_tag
);

  logic                     rst_core_n;
  logic [WORD_W-1:0]        src_word [NUM_OPERANDS];
  logic                     src_hi   [NUM_OPERANDS];
  logic signed [HALF_W-1:0] op_half  [NUM_OPERANDS];
  logic signed [PROD_W-1:0] prod_comb;

  pkhm_rst_sync #(
    .STAGES(SYNC_STAGES)
  ) u_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_core_n(rst_core_n)
  );

  always_comb begin
    src_word[0] = a_word;
    src_word[1] = b_word;
    src_hi[0]   = a_hi;
    src_hi[1]   = b_hi;
  end

  for (genvar g = 0; g < NUM_OPERANDS; g++) begin : g_pick
    pkhm_half_pick #(
      .HALF_W(HALF_W)
    ) u_pick (
      .word(src_word[g]),
      .hi  (src_hi[g]),
      .half(op_half[g])
    );
  end

  pkhm_smul #(
    .HALF_W(HALF_W)
  ) u_smul (
    .x(op_half[0]),
    .y(op_half[1]),
    .p(prod_comb)
  );

  pkhm_out_stage #(
    .PROD_W(PROD_W),
    .TAG_W (TAG_W)
  ) u_out (
    .clk       (clk),
    .rst_core_n(rst_core_n),
    .en        (in_valid),
    .prod_d    (prod_comb),
    .tag_d     (in_tag),
    .valid_q   (out_valid),
    .prod_q    (out_prod),
    .tag_q     (out_tag)
  );

endmodule

// File: rtl/pkmul_unit_chk.sv
module pkmul_unit_chk #(
  parameter int unsigned HALF_W = 16,
  parameter int unsigned TAG_W  = 5,
  localparam int unsigned WORD_W = 2 * HALF_W,
  localparam int unsigned PROD_W = 2 * HALF_W
) (
  input logic              clk,
  input logic              rst_core_n,
  input logic              in_valid,
  input logic [WORD_W-1:0] a_word,
  input logic [WORD_W-1:0] b_word,
  input logic              a_hi,
  input logic              b_hi,
  input logic [TAG_W-1:0]  in_tag,
  input logic              out_valid,
  input logic [PROD_W-1:0] out_prod,
  input logic [TAG_W-1:0]  out_tag
);

  logic signed [PROD_W-1:0] ref_a;
  logic signed [PROD_W-1:0] ref_b;
  logic [PROD_W-1:0]        ref_prod;
  logic                     corner_in;

  always_comb begin
    ref_a     = a_hi ? PROD_W'($signed(a_word[WORD_W-1:HALF_W])) : PROD_W'($signed(a_word[HALF_W-1:0]));
    ref_b     = b_hi ? PROD_W'($signed(b_word[WORD_W-1:HALF_W])) : PROD_W'($signed(b_word[HALF_W-1:0]));
    ref_prod  = ref_a * ref_b;
    corner_in = (ref_a == -(PROD_W'(1) << (HALF_W - 1))) && (ref_b == -(PROD_W'(1) << (HALF_W - 1)));
  end

  // R1: outputs cleared while the core reset is held
  always @(posedge clk) begin
    if (!rst_core_n) begin
      a_r1_reset_clear: assert (!out_valid && out_prod == '0 && out_tag == '0)
        else $error("a_r1_reset_clear");
    end
  end

  // R2, R3, R9: selected halves multiplied, result one cycle later
  a_r3_product: assert property (@(posedge clk) disable iff (!rst_core_n)
    in_valid |=> out_prod == $past(ref_prod));

  // R4: most-negative squared lands on the single positive corner
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_core_n)
    (in_valid && corner_in) |=> out_prod == (PROD_W'(1) << (PROD_W - 2)));

  // R5: valid follows the strobe by one cycle
  a_r5_valid_follow: assert property (@(posedge clk) disable iff (!rst_core_n)
    in_valid |=> out_valid);

  a_r5_valid_idle: assert property (@(posedge clk) disable iff (!rst_core_n)
    !in_valid |=> !out_valid);

  // R6: tag travels with the data
  a_r6_tag_carry: assert property (@(posedge clk) disable iff (!rst_core_n)
    in_valid |=> out_tag == $past(in_tag));

  // R7: outputs hold without a strobe
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_core_n)
    !in_valid |=> ($stable(out_prod) && $stable(out_tag)));

endmodule

bind pkmul_unit pkmul_unit_chk #(
  .HALF_W(HALF_W),
  .TAG_W (TAG_W)
) u_chk (
  .clk       (clk),
  .rst_core_n(rst_core_n),
  .in_valid  (in_valid),
  .a_word    (a_word),
  .b_word    (b_word),
  .a_hi      (a_hi),
  .b_hi      (b_hi),
  .in_tag    (in_tag),
  .out_valid (out_valid),
  .out_prod  (out_prod),
  .out_tag   (out_tag)
);

// File: tb/pkmul_unit_test.sv
module pkmul_unit_test;

  localparam int unsigned NVEC = 12;
  // Vector layout: {a_word[32], b_word[32], a_hi, b_hi, expected[32]}
  localparam logic [97:0] VEC [NVEC] = '{
    {32'h0003_0005, 32'h0007_0002, 1'b0, 1'b0, 32'h0000_000A}, // R2 lo x lo
    {32'h0003_0005, 32'h0007_0002, 1'b1, 1'b1, 32'h0000_0015}, // R2 hi x hi
    {32'h0003_0005, 32'h0007_0002, 1'b1, 1'b0, 32'h0000_0006}, // R2 hi x lo
    {32'h0003_0005, 32'h0007_0002, 1'b0, 1'b1, 32'h0000_0023}, // R2 lo x hi
    {32'hFFFF_0004, 32'h0000_0100, 1'b1, 1'b0, 32'hFFFF_FF00}, // R3 -1 x 256
    {32'h8000_1234, 32'h5678_8000, 1'b1, 1'b1, 32'hD4C4_0000}, // R3 min x positive
    {32'h8000_0000, 32'h0000_8000, 1'b1, 1'b0, 32'h4000_0000}, // R4 corner
    {32'h0000_7FFF, 32'h7FFF_0000, 1'b0, 1'b1, 32'h3FFF_0001}, // R3 max x max
    {32'h7FFF_1111, 32'h2222_8000, 1'b1, 1'b0, 32'hC000_8000}, // R3 max x min
    {32'h0000_FFFF, 32'hFFFF_0000, 1'b0, 1'b1, 32'h0000_0001}, // R3 -1 x -1
    {32'h1234_0000, 32'hFFFF_7FFF, 1'b0, 1'b0, 32'h0000_0000}, // R3 zero
    {32'hABCD_0005, 32'h9999_0002, 1'b0, 1'b0, 32'h0000_000A}  // R8 other halves differ
  };

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] a_word;
  logic [31:0] b_word;
  logic        a_hi;
  logic        b_hi;
  logic [4:0]  in_tag;
  logic        out_valid;
  logic [31:0] out_prod;
  logic [4:0]  out_tag;

  int tests;
  int fails;

  pkmul_unit uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .a_word   (a_word),
    .b_word   (b_word),
    .a_hi     (a_hi),
    .b_hi     (b_hi),
    .in_tag   (in_tag),
    .out_valid(out_valid),
    .out_prod (out_prod),
    .out_tag  (out_tag)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] last_prod;
    logic [4:0]  last_tag;
    tests = 0;
    fails = 0;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    a_word   = '0;
    b_word   = '0;
    a_hi     = 1'b0;
    b_hi     = 1'b0;
    in_tag   = '0;

    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 valid", 32'(out_valid), 32'd0);
    chk("R1 prod", out_prod, 32'd0);
    chk("R1 tag", 32'(out_tag), 32'd0);

    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R9: table walked with in_valid high every cycle
    for (int i = 0; i < NVEC; i++) begin
      a_word   = VEC[i][97:66];
      b_word   = VEC[i][65:34];
      a_hi     = VEC[i][33];
      b_hi     = VEC[i][32];
      in_tag   = 5'(i + 3);
      in_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      chk($sformatf("R3 R9 vec %0d prod", i), out_prod, VEC[i][31:0]);
      chk($sformatf("R5 vec %0d valid", i), 32'(out_valid), 32'd1);
      chk($sformatf("R6 vec %0d tag", i), 32'(out_tag), 32'(i + 3));
    end
    last_prod = VEC[NVEC-1][31:0];
    last_tag  = 5'(NVEC + 2);

    // R7: strobe low, inputs change, outputs hold
    in_valid = 1'b0;
    a_word   = 32'h8000_8000;
    b_word   = 32'h7FFF_7FFF;
    a_hi     = 1'b1;
    b_hi     = 1'b1;
    in_tag   = 5'd31;
    @(posedge clk);
    @(negedge clk);
    chk("R5 valid drops", 32'(out_valid), 32'd0);
    a_word = 32'h0001_0001;
    @(posedge clk);
    @(negedge clk);
    chk("R7 prod held", out_prod, last_prod);
    chk("R7 tag held", 32'(out_tag), 32'(last_tag));

    // R4: corner driven again with lower halves
    a_word   = 32'h1111_8000;
    b_word   = 32'h2222_8000;
    a_hi     = 1'b0;
    b_hi     = 1'b0;
    in_tag   = 5'd9;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R4 corner lo x lo", out_prod, 32'h4000_0000);

    // R1: reset applied mid-run clears outputs at once
    in_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R1 mid-run valid", 32'(out_valid), 32'd0);
    chk("R1 mid-run prod", out_prod, 32'd0);
    chk("R1 mid-run tag", 32'(out_tag), 32'd0);

    @(negedge clk);
    finish_run();
  end

endmodule